// File: doc/BRIEF.md
# Shared Packed-Integer and Significand Multiplier

This block is a two-stage pipelined multiplier array that serves two kinds of work from one set of hardware. In the packed integer modes each 64-bit operand holds four signed 16-bit lanes. The block forms the four lane products and returns, per lane, the low half, the high half, or the high half after rounding. In significand mode each 64-bit operand holds two single-precision values. The block restores the hidden bit of each 23-bit fraction, multiplies the two 24-bit significands and returns the upper 32 bits of each 48-bit product. Exponent handling and normalisation are left to the logic around the block.

Each 32-bit half of the operands feeds its own radix-4 Booth array of 17 partial-product rows. A carry-save tree of 4-2 and 3-2 compressors reduces these rows. In packed modes the array is split by operand alignment: the low Booth digits multiply only the low lanes and the high digits multiply only the high lanes, so the cross terms never appear. Carries are also cut at the 32-bit lane-field boundary. Stage one holds the redundant sum and carry vectors. Stage two holds the two 64-bit carry-propagate adders and the field selection. One operation may enter on every cycle, and the mode travels with its operands through the pipeline.

Top module: `simd_mul_array`

## Requirements
- R1: With mode 2'b00, each 16-bit lane i of the result (bits 16i+15 down to 16i) is the low 16 bits of the signed product of lane i of A and lane i of B.
- R2: With mode 2'b01, each 16-bit lane of the result is bits 31:16 of the signed 32-bit product of the matching lanes.
- R3: With mode 2'b10, each 16-bit lane of the result is bits 31:16 of (signed lane product + 0x8000), taken modulo 2^32.
- R4: With mode 2'b11, each 32-bit half h of A and B is read as a single-precision value. The significand is 1 followed by bits 22:0, so sign and exponent bits 31:23 have no effect. Result half h is bits 47:16 of the unsigned 48-bit product of the two significands.
- R5: Lanes are independent: a lane's result depends only on that lane's operands, whatever values sit in the other lanes.
- R6: An operation presented with inValid high at a rising edge appears on outResult, with outValid high, right after the second rising edge that follows. outValid is high only for such operations, and a new operation is accepted every cycle.
- R7: The mode is captured with its operands, so back-to-back operations in different modes each produce their own mode's result.
- R8: While no operation completes, outValid is low and outResult keeps the last completed result.
- R9: During and right after reset, outValid is 0 and outResult is 0.
- R10: Extreme operands are exact: 0x8000 × 0x8000 gives low 0x0000, high 0x4000 and rounded 0x4000 per lane. All-ones fractions (significand 0xFFFFFF) give 0xFFFFFE00 per half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present on inMode, inA and inB |
| inMode | input | 2 | 00 low lanes, 01 high lanes, 10 rounded high lanes, 11 significand |
| inA | input | 64 | First operand |
| inB | input | 64 | Second operand |
| outValid | output | 1 | Result of an operation issued two edges earlier |
| outResult | output | 64 | Selected product fields |

## Verification
On every cycle, the embedded assertions compare the registered result against a behavioural product of the operands captured two edges earlier, for each of the four modes. They also tie outValid to inValid two edges back. Other behaviours can only be shown by the bench's scenarios. These include lane independence under extreme neighbours, holding of the output across idle gaps, the reset values, and the rounding boundary where the rounded high half wraps to zero. The same applies to the exact arrival cycle of each item in long runs of mixed modes issued back to back.

// File: rtl/mul_pkg.sv
package mul_pkg;

  localparam int DATA_W      = 64;
  localparam int HALF_W      = 32;
  localparam int LANE_W      = 16;
  localparam int FRAC_W      = 23;
  localparam int SIG_W       = FRAC_W + 1;
  localparam int NUM_HALVES  = DATA_W / HALF_W;
  localparam int NUM_LANES   = DATA_W / LANE_W;
  localparam int NUM_DIGITS  = HALF_W / 2;
  localparam int NUM_PP      = NUM_DIGITS + 1;
  localparam int LANE_DIGITS = LANE_W / 2;

  typedef enum logic [1:0] {
    MODE_LO  = 2'b00,
    MODE_HI  = 2'b01,
    MODE_RND = 2'b10,
    MODE_SIG = 2'b11
  } mulMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     captureS1;
    logic     captureS2;
    mulMode_e fmtMode;
    mulMode_e selMode;
  } mulStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] s;
    logic [DATA_W-1:0] c;
  } csaPair_t;

  // Full adder row; carries crossing a zero bit of keep are discarded
  function automatic csaPair_t csa3(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                                    input logic [DATA_W-1:0] z, input logic [DATA_W-1:0] keep);
    csaPair_t r;
    r.s = x ^ y ^ z;
    r.c = (((x & y) | (x & z) | (y & z)) << 1) & keep;
    return r;
  endfunction

  function automatic csaPair_t csa42(input logic [DATA_W-1:0] w, input logic [DATA_W-1:0] x,
                                     input logic [DATA_W-1:0] y, input logic [DATA_W-1:0] z,
                                     input logic [DATA_W-1:0] keep);
    csaPair_t t;
    t = csa3(w, x, y, keep);
    return csa3(t.s, t.c, z, keep);
  endfunction

  // Behavioural references used by the embedded checks
  function automatic logic [DATA_W-1:0] refPacked(input mulMode_e m, input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    logic [HALF_W-1:0] pa, pb, p, pr;
    r = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      pa = {{(HALF_W-LANE_W){a[LANE_W*i+LANE_W-1]}}, a[LANE_W*i +: LANE_W]};
      pb = {{(HALF_W-LANE_W){b[LANE_W*i+LANE_W-1]}}, b[LANE_W*i +: LANE_W]};
      p  = pa * pb;
      pr = p + (HALF_W'(1) << (LANE_W-1));
      case (m)
        MODE_LO: r[LANE_W*i +: LANE_W] = p[LANE_W-1:0];
        MODE_HI: r[LANE_W*i +: LANE_W] = p[HALF_W-1:LANE_W];
        default: r[LANE_W*i +: LANE_W] = pr[HALF_W-1:LANE_W];
      endcase
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] refSig(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    logic [2*SIG_W-1:0] sa, sb, p;
    for (int h = 0; h < NUM_HALVES; h++) begin
      sa = (2*SIG_W)'({1'b1, a[HALF_W*h +: FRAC_W]});
      sb = (2*SIG_W)'({1'b1, b[HALF_W*h +: FRAC_W]});
      p  = sa * sb;
      r[HALF_W*h +: HALF_W] = p[2*SIG_W-1 -: HALF_W];
    end
    return r;
  endfunction

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  mulMode_e   inMode,
  output mulStrobe_t strobe,
  output logic       outValid
);

  logic     s1Valid;
  mulMode_e s1Mode;
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Mode   <= MODE_LO;
      outValid <= 1'b0;
      sinceRst <= '0;
    end else begin
      s1Valid  <= inValid;
      if (inValid) s1Mode <= inMode;
      outValid <= s1Valid;
      if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
    end
  end

  always_comb begin
    strobe.captureS1 = inValid;
    strobe.fmtMode   = inMode;
    strobe.captureS2 = s1Valid;
    strobe.selMode   = s1Mode;
  end

  // R6: completion follows issue by exactly two edges
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (outValid == $past(inValid, 2)));

endmodule

// File: rtl/mul_booth_array.sv
module mul_booth_array
  import mul_pkg::*;
(
  input  mulMode_e          mode,
  input  logic [HALF_W-1:0] aHalf,
  input  logic [HALF_W-1:0] bHalf,
  output logic [DATA_W-1:0] ppRow [NUM_PP]
);

  localparam logic [DATA_W-1:0] LOW_FIELD = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] ROUND_ROW =
    (DATA_W'(1) << (LANE_W-1)) | (DATA_W'(1) << (HALF_W+LANE_W-1));

  logic packedMode;
  logic [HALF_W-1:0] bOp;
  logic [HALF_W:0]   wPad;
  logic [DATA_W-1:0] aSigExt, aLoExt, aHiExt;

  // Format selection
  always_comb begin
    packedMode = (mode != MODE_SIG);
    bOp     = packedMode ? bHalf : {{(HALF_W-SIG_W){1'b0}}, 1'b1, bHalf[FRAC_W-1:0]};
    wPad    = {bOp, 1'b0};
    aSigExt = {{(DATA_W-SIG_W){1'b0}}, 1'b1, aHalf[FRAC_W-1:0]};
    aLoExt  = {{(DATA_W-LANE_W){aHalf[LANE_W-1]}}, aHalf[LANE_W-1:0]};
    aHiExt  = {{(DATA_W-LANE_W){aHalf[HALF_W-1]}}, aHalf[HALF_W-1:LANE_W]};
  end

  for (genvar j = 0; j < NUM_DIGITS; j++) begin : gDigit
    logic [2:0]        triple;
    logic [DATA_W-1:0] mcand, sel, shifted;

    always_comb begin
      triple = wPad[2*j +: 3];
      // the first high-lane digit must not see the low lane's sign bit
      if (packedMode && j == LANE_DIGITS) triple[0] = 1'b0;
      if (!packedMode)          mcand = aSigExt;
      else if (j < LANE_DIGITS) mcand = aLoExt;
      else                      mcand = aHiExt;
      case (triple)
        3'b001, 3'b010: sel = mcand;
        3'b011:         sel = mcand << 1;
        3'b100:         sel = -(mcand << 1);
        3'b101, 3'b110: sel = -mcand;
        default:        sel = '0;
      endcase
    end

    if (j < LANE_DIGITS) begin : gLow
      always_comb shifted = packedMode ? ((sel << (2*j)) & LOW_FIELD) : (sel << (2*j));
    end else begin : gHigh
      always_comb shifted = packedMode ? (sel << (2*(j-LANE_DIGITS) + HALF_W)) : (sel << (2*j));
    end

    assign ppRow[j] = shifted;
  end

  // The top Booth digit is always zero (sign-extended lanes, zero-padded
  // significands), so that row carries the rounding constant instead.
  assign ppRow[NUM_PP-1] = (mode == MODE_RND) ? ROUND_ROW : '0;

endmodule

// File: rtl/mul_csa_tree.sv
module mul_csa_tree
  import mul_pkg::*;
(
  input  logic [DATA_W-1:0] ppRow [NUM_PP],
  input  logic [DATA_W-1:0] keepMask,
  output logic [DATA_W-1:0] sumVec,
  output logic [DATA_W-1:0] carryVec
);

  localparam int L1 = (NUM_PP - 1) / 2;
  localparam int L2 = L1 / 2;

  logic [DATA_W-1:0] lvl1 [L1];
  logic [DATA_W-1:0] lvl2 [L2];
  csaPair_t t, fin;

  always_comb begin
    for (int i = 0; i < L1 / 2; i++) begin
      t = csa42(ppRow[4*i], ppRow[4*i+1], ppRow[4*i+2], ppRow[4*i+3], keepMask);
      lvl1[2*i]   = t.s;
      lvl1[2*i+1] = t.c;
    end
    for (int i = 0; i < L2 / 2; i++) begin
      t = csa42(lvl1[4*i], lvl1[4*i+1], lvl1[4*i+2], lvl1[4*i+3], keepMask);
      lvl2[2*i]   = t.s;
      lvl2[2*i+1] = t.c;
    end
    t   = csa42(lvl2[0], lvl2[1], lvl2[2], lvl2[3], keepMask);
    fin = csa3(t.s, t.c, ppRow[NUM_PP-1], keepMask);
    sumVec   = fin.s;
    carryVec = fin.c;
  end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobe_t        strobe,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic [DATA_W-1:0] resultQ
);

  localparam logic [DATA_W-1:0] CUT_MASK = ~(DATA_W'(1) << HALF_W);

  logic [DATA_W-1:0] keepS1;
  logic [DATA_W-1:0] sumD   [NUM_HALVES];
  logic [DATA_W-1:0] carryD [NUM_HALVES];
  logic [DATA_W-1:0] sumQ   [NUM_HALVES];
  logic [DATA_W-1:0] carryQ [NUM_HALVES];
  logic [DATA_W-1:0] cpaOut [NUM_HALVES];
  logic [DATA_W-1:0] resultD;
  logic packedS2;

  assign keepS1   = (strobe.fmtMode != MODE_SIG) ? CUT_MASK : '1;
  assign packedS2 = (strobe.selMode != MODE_SIG);

  // Stage 1: format selection, Booth rows, carry-save reduction per half
  for (genvar h = 0; h < NUM_HALVES; h++) begin : gHalf
    logic [DATA_W-1:0] rows [NUM_PP];
    logic [HALF_W:0]   lowSum;
    logic [HALF_W-1:0] highSum;

    mul_booth_array u_booth (
      .mode  (strobe.fmtMode),
      .aHalf (inA[HALF_W*h +: HALF_W]),
      .bHalf (inB[HALF_W*h +: HALF_W]),
      .ppRow (rows)
    );

    mul_csa_tree u_tree (
      .ppRow    (rows),
      .keepMask (keepS1),
      .sumVec   (sumD[h]),
      .carryVec (carryD[h])
    );

    // Stage 2 carry-propagate adder, carry cut at the lane field in packed modes
    always_comb begin
      lowSum  = {1'b0, sumQ[h][HALF_W-1:0]} + {1'b0, carryQ[h][HALF_W-1:0]};
      highSum = sumQ[h][DATA_W-1:HALF_W] + carryQ[h][DATA_W-1:HALF_W]
              + HALF_W'(!packedS2 && lowSum[HALF_W]);
      cpaOut[h] = {highSum, lowSum[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int h = 0; h < NUM_HALVES; h++) begin
        sumQ[h]   <= '0;
        carryQ[h] <= '0;
      end
    end else if (strobe.captureS1) begin
      for (int h = 0; h < NUM_HALVES; h++) begin
        sumQ[h]   <= sumD[h];
        carryQ[h] <= carryD[h];
      end
    end
  end

  // Stage 2 field selection
  always_comb begin
    resultD = '0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (!packedS2) begin
        resultD[HALF_W*h +: HALF_W] = cpaOut[h][2*SIG_W-1 -: HALF_W];
      end else begin
        for (int f = 0; f < 2; f++) begin
          if (strobe.selMode == MODE_LO)
            resultD[HALF_W*h + LANE_W*f +: LANE_W] = cpaOut[h][HALF_W*f +: LANE_W];
          else
            resultD[HALF_W*h + LANE_W*f +: LANE_W] = cpaOut[h][HALF_W*f + LANE_W +: LANE_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 resultQ <= '0;
    else if (strobe.captureS2) resultQ <= resultD;
  end

  // Results against behavioural products of the operands from two edges back
  assert_low_lanes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureS2 && strobe.selMode == MODE_LO)
      |=> (resultQ == refPacked(MODE_LO, $past(inA, 2), $past(inB, 2))));

  assert_high_lanes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureS2 && strobe.selMode == MODE_HI)
      |=> (resultQ == refPacked(MODE_HI, $past(inA, 2), $past(inB, 2))));

  assert_round_lanes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureS2 && strobe.selMode == MODE_RND)
      |=> (resultQ == refPacked(MODE_RND, $past(inA, 2), $past(inB, 2))));

  assert_sig_product_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureS2 && strobe.selMode == MODE_SIG)
      |=> (resultQ == refSig($past(inA, 2), $past(inB, 2))));

endmodule

// File: rtl/simd_mul_array.sv
module simd_mul_array
  import mul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  inMode,
  input  logic [63:0] inA,
  input  logic [63:0] inB,
  output logic        outValid,
  output logic [63:0] outResult
);

  mulStrobe_t strobe;

  mul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMode   (mulMode_e'(inMode)),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mul_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inA     (inA),
    .inB     (inB),
    .resultQ (outResult)
  );

endmodule

// File: tb/simd_mul_array_bench.sv
module simd_mul_array_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inMode = 2'b00;
  logic [63:0] inA = '0;
  logic [63:0] inB = '0;
  logic        outValid;
  logic [63:0] outResult;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  bit haveLast = 0;
  logic [63:0] lastRes = '0;

  typedef struct {
    logic [63:0] exp;
    int          cyc;
    string       tag;
  } item_t;
  item_t sbq[$];

  simd_mul_array u_simd_mul_array (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .inA(inA), .inB(inB), .outValid(outValid), .outResult(outResult)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic signed [31:0] p;
    logic [31:0] pr;
    logic [47:0] sp;
    r = '0;
    if (m == 2'b11) begin
      for (int h = 0; h < 2; h++) begin
        sp = {25'd0, 1'b1, a[32*h +: 23]} * {25'd0, 1'b1, b[32*h +: 23]};
        r[32*h +: 32] = sp[47:16];
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        p  = $signed(a[16*i +: 16]) * $signed(b[16*i +: 16]);
        pr = p + 32'h8000;
        if (m == 2'b00)      r[16*i +: 16] = p[15:0];
        else if (m == 2'b01) r[16*i +: 16] = p[31:16];
        else                 r[16*i +: 16] = pr[31:16];
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b, input string tag);
    item_t it;
    @(negedge clk);
    inMode = m; inA = a; inB = b; inValid = 1'b1;
    it.exp = model(m, a, b);
    it.cyc = cyc;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
      inA = $urandom(); inB = {$urandom(), $urandom()};
    end
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Monitor: pops the scoreboard as results arrive
  always @(negedge clk) begin
    item_t it;
    if (rstN && !finished) begin
      if (outValid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R6 unexpected outValid", outResult, '0);
        end else begin
          it = sbq.pop_front();
          check(cyc == it.cyc + 2, {it.tag, " R6 arrival cycle"}, 64'(cyc), 64'(it.cyc + 2));
          check(outResult == it.exp, it.tag, outResult, it.exp);
          lastRes  = outResult;
          haveLast = 1;
        end
      end else if (haveLast) begin
        check(outResult == lastRes, "R8 hold while idle", outResult, lastRes);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] m;
    // R9: reset values
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R9 outValid in reset", 64'(outValid), 64'd0);
    check(outResult == '0, "R9 outResult in reset", outResult, '0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R9 outValid after reset", 64'(outValid), 64'd0);
    check(outResult == '0, "R9 outResult after reset", outResult, '0);

    // R10: extreme lane values in every packed mode
    issue(2'b00, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R10/R1");
    issue(2'b01, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R10/R2");
    issue(2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R10/R3");
    // R3: rounding boundaries (wrap to zero, 0x7FFF squared)
    issue(2'b10, 64'h0001_7FFF_0001_7FFF, 64'h8000_7FFF_8000_7FFF, "R3 boundary");
    issue(2'b01, 64'h0001_7FFF_FFFF_0003, 64'h8000_7FFF_FFFF_FFFD, "R2 boundary");
    // R5: lane independence with extreme neighbours
    issue(2'b00, 64'h8000_FFFF_8000_0003, 64'h8000_FFFF_8000_0005, "R5");
    issue(2'b01, 64'h7FFF_8000_FFFF_0000, 64'h7FFF_8000_0001_1234, "R5");
    issue(2'b10, 64'h0000_8000_0000_8000, 64'h8000_0000_8000_0000, "R5");
    // R4 and R10: all-ones fractions, unit significands, sign/exponent noise
    issue(2'b11, 64'h007F_FFFF_007F_FFFF, 64'h007F_FFFF_007F_FFFF, "R10/R4");
    issue(2'b11, 64'hFF80_0000_3F80_0000, 64'h4000_0000_BF80_0000, "R4");
    issue(2'b11, 64'hC07F_FFFF_0000_0000, 64'h8000_0001_FFFF_FFFF, "R4");
    idle(4);

    // R7: back-to-back operations in mixed modes, random operands
    for (int n = 0; n < 300; n++) begin
      m = 2'($urandom_range(0, 3));
      issue(m, {$urandom(), $urandom()}, {$urandom(), $urandom()}, {"R7/", modeTag(m)});
      if ((n % 37) == 36) idle(3);
    end
    // R6: one per cycle alternating modes
    for (int n = 0; n < 40; n++) begin
      m = 2'(n % 4);
      issue(m, {$urandom(), $urandom()}, {$urandom(), $urandom()}, {"R6/", modeTag(m)});
    end
    idle(6);
    check(sbq.size() == 0, "R6 all results arrived", 64'(sbq.size()), 64'd0);
    check(outValid == 1'b0, "R8 outValid low when idle", 64'(outValid), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule